// File: doc/BRIEF.md
# Frame-Checked Serial Command Port

This block is the serial slave port of a multi-channel output driver. A host lowers the chip select, clocks a command word in on the data input with the most significant bit first, and clocks a diagnostic word out on the data output at the same time. When the host raises the chip select, the port checks how many bits arrived. It hands the received word to the driver core only when that count is an acceptable frame length.

All four serial pins are brought into the system clock domain through synchronizers, and every serial edge is detected there. A sticky transmission-error flag can be read without clocking. From the chip-select fall until the first rising serial clock, the data output shows that flag ORed with the incoming data level, so an error raised anywhere in a chain of these ports reaches the host. Frames longer than one word make the port act as a 16-bit delay stage, so several ports can share one chip select in a daisy chain.

Top module: `spi_frame_slave`

## Requirements
- R1: While reset is held low and after its release, `sdo_oe_o` is 0, `sdo_o` is 0, `cmd_stb_o` is 0, `cmd_word_o` holds the parameter `CMD_RST` (default 16'hFFFF), and the error flag is 1.
- R2: Data is sampled on each falling edge of `sclk_i`. At the end of a valid frame, the last 16 bits sampled (the first one in bit 15) appear on `cmd_word_o` together with a `cmd_stb_o` pulse of one clock. `cmd_word_o` changes at no other time.
- R3: `diag_word_i` is captured when the chip select falls, and changes after that have no effect on the frame. The first 16 bits shifted out on `sdo_o`, each one updated on a rising `sclk_i` edge, are the captured word, bit 15 first.
- R4: From the 17th rising `sclk_i` edge onward, `sdo_o` repeats the bits sampled on `sdi_i`, delayed by 16 bit times.
- R5: A frame is valid only when the number of falling `sclk_i` edges during a low `cs_n_i` is at least 16 and a multiple of 8; a frame with no clocks at all counts as invalid. An invalid frame produces no strobe, leaves `cmd_word_o` unchanged and sets the error flag.
- R6: From the chip-select fall until the first rising `sclk_i` edge, `sdo_o` equals the error flag ORed with the synchronized `sdi_i` level.
- R7: A valid frame clears the error flag. A one-clock pulse on `err_set_i` sets it, and the set wins when both occur in the same clock.
- R8: `sdo_oe_o` is 1 only while the synchronized chip select is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every serial pin is oversampled on it |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n_i | input | 1 | Chip select, active low, asynchronous |
| sclk_i | input | 1 | Serial clock, idles low, asynchronous |
| sdi_i | input | 1 | Serial data input |
| sdo_o | output | 1 | Serial data output (0 while disabled) |
| sdo_oe_o | output | 1 | Output enable for the external tri-state pad |
| diag_word_i | input | 16 | Diagnostic word to shift out |
| err_set_i | input | 1 | Pulse from the mode logic that sets the error flag |
| cmd_word_o | output | 16 | Last accepted command word |
| cmd_stb_o | output | 1 | One-clock pulse when `cmd_word_o` is updated |

## Verification
Each serial pin passes through two synchronizer flops and one edge register, so every result is due three clock edges after the pin changes. That holds for an `sdo_o` update after a rising serial clock, for the capture of a word, and for `cmd_stb_o` after the chip select rises. The bench holds every serial phase for eight clocks and reads `sdo_o` only at the end of a phase, well after the three-edge latency, and it changes `sdi_i` only in the middle of the high phase so that data never passes through the synchronizers alongside a clock edge. Command strobes may occur at any clock after the chip select rises, so a monitor pops them from the expected queue whenever they appear and flags any strobe that has no expected entry.

// File: rtl/spi_frame_pkg.sv
// Package: shared types and helpers for the frame-checked serial port.
// Assumes: frame-length units are powers of two.
package spi_frame_pkg;

    // Serial events detected in the system clock domain, one clock wide.
    typedef struct packed {
        logic cs_fall;
        logic cs_rise;
        logic sck_rise;
        logic sck_fall;
    } spi_evt_t;

    // True when a bit count is an acceptable frame length.
    function automatic logic frame_len_ok(input int unsigned n_bits,
                                          input int unsigned min_bits,
                                          input int unsigned unit_bits);
        return (n_bits >= min_bits) && ((n_bits % unit_bits) == 0);
    endfunction

endpackage

// File: rtl/spi_in_sync.sv
// Module: multi-bit level synchronizer with edge detection.
// What it does: passes W asynchronous inputs through STAGES flops and flags
// the rising and falling edges of the synchronized level.
// Assumes: each input bit is an independent slow signal; latency to the edge
// flags is STAGES clocks.
module spi_in_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);

    logic [STAGES-1:0][W-1:0] pipe;
    logic [W-1:0]             prev_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage: capture the raw asynchronous inputs.
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe[0] <= RST_VAL;
                    else        pipe[0] <= d_i;
                end
            end else begin : g_next
                // Later stages: settle metastability.
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe[g] <= RST_VAL;
                    else        pipe[g] <= pipe[g-1];
                end
            end
        end
    endgenerate

    // Previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= pipe[STAGES-1];
    end

    assign q_o    = pipe[STAGES-1];
    assign rise_o = pipe[STAGES-1] & ~prev_q;
    assign fall_o = ~pipe[STAGES-1] & prev_q;

endmodule

// File: rtl/spi_bit_counter.sv
// Module: frame bit counter and length checker.
// What it does: counts sampled bits in one chip-select window and reports
// whether the count is an acceptable frame length.
// Assumes: the counter saturates at all ones, which is never a legal length,
// so a frame that overruns the counter is rejected.
module spi_bit_counter
    import spi_frame_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int MIN_BITS = 16,
    parameter int UNIT_W   = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  spi_evt_t evt_i,
    input  logic     active_i,
    output logic     len_ok_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    // Restart at each chip-select fall; count sampling edges while selected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (evt_i.cs_fall) begin
            cnt_q <= '0;
        end else if (active_i && evt_i.sck_fall && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign len_ok_o = frame_len_ok(int'(cnt_q), MIN_BITS, UNIT_W);

endmodule

// File: rtl/spi_shift_path.sv
// Module: serial data path.
// What it does: loads the diagnostic word at chip-select fall, shifts input
// bits in on sampling edges, drives the output bit on launch edges, and shows
// the error flag ORed with the input level before the first launch edge.
// Assumes: the serial clock is low whenever the chip select changes.
module spi_shift_path
    import spi_frame_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  spi_evt_t          evt_i,
    input  logic              active_i,
    input  logic              sdi_s_i,
    input  logic              err_flag_i,
    input  logic [WORD_W-1:0] diag_word_i,
    output logic [WORD_W-1:0] rx_word_o,
    output logic              sdo_o,
    output logic              sdo_oe_o
);

    logic [WORD_W-1:0] shreg_q;
    logic              so_q;
    logic              win_q;

    // Shift register: parallel load at select, serial shift on sampling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
        end else if (evt_i.cs_fall) begin
            shreg_q <= diag_word_i;
        end else if (active_i && evt_i.sck_fall) begin
            shreg_q <= {shreg_q[WORD_W-2:0], sdi_s_i};
        end
    end

    // Output bit register: takes the shift register head on launch edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            so_q <= 1'b0;
        end else if (evt_i.cs_fall) begin
            so_q <= 1'b0;
        end else if (active_i && evt_i.sck_rise) begin
            so_q <= shreg_q[WORD_W-1];
        end
    end

    // Error window: open from idle until the first launch edge of a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= 1'b1;
        end else if (evt_i.cs_rise || evt_i.cs_fall) begin
            win_q <= 1'b1;
        end else if (active_i && evt_i.sck_rise) begin
            win_q <= 1'b0;
        end
    end

    // Output mux: error window or shifted data, forced low while deselected.
    always_comb begin
        if (!active_i)  sdo_o = 1'b0;
        else if (win_q) sdo_o = err_flag_i | sdi_s_i;
        else            sdo_o = so_q;
    end

    assign sdo_oe_o  = active_i;
    assign rx_word_o = shreg_q;

endmodule

// File: rtl/spi_frame_slave.sv
// Module: frame-checked serial command port (top).
// What it does: synchronizes the serial pins, runs the data path and bit
// counter, latches accepted command words and keeps the sticky error flag.
// Assumes: the system clock is at least several times faster than the serial
// clock, so every serial phase spans three or more system clocks.
module spi_frame_slave
    import spi_frame_pkg::*;
#(
    parameter int                 WORD_W   = 16,
    parameter int                 UNIT_W   = 8,
    parameter int                 CNT_W    = 8,
    parameter int                 STAGES   = 2,
    parameter logic [WORD_W-1:0]  CMD_RST  = {WORD_W{1'b1}}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              sclk_i,
    input  logic              sdi_i,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    input  logic [WORD_W-1:0] diag_word_i,
    input  logic              err_set_i,
    output logic [WORD_W-1:0] cmd_word_o,
    output logic              cmd_stb_o
);

    localparam int PIN_N   = 3;
    localparam int PIN_CS  = 0;
    localparam int PIN_SCK = 1;
    localparam int PIN_SDI = 2;
    localparam logic [PIN_N-1:0] PIN_IDLE = 3'b001;

    logic [PIN_N-1:0]  pin_lvl, pin_rise, pin_fall;
    spi_evt_t          evt;
    logic              active;
    logic              len_ok;
    logic              err_q;
    logic [WORD_W-1:0] rx_word;

    spi_in_sync #(
        .W(PIN_N), .STAGES(STAGES), .RST_VAL(PIN_IDLE)
    ) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_i({sdi_i, sclk_i, cs_n_i}),
        .q_o(pin_lvl), .rise_o(pin_rise), .fall_o(pin_fall)
    );

    // Event bundle for the data path and counter.
    always_comb begin
        evt.cs_fall  = pin_fall[PIN_CS];
        evt.cs_rise  = pin_rise[PIN_CS];
        evt.sck_rise = pin_rise[PIN_SCK];
        evt.sck_fall = pin_fall[PIN_SCK];
    end

    assign active = ~pin_lvl[PIN_CS];

    spi_bit_counter #(
        .CNT_W(CNT_W), .MIN_BITS(WORD_W), .UNIT_W(UNIT_W)
    ) u_cnt (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .active_i(active),
        .len_ok_o(len_ok)
    );

    spi_shift_path #(
        .WORD_W(WORD_W)
    ) u_path (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .active_i(active),
        .sdi_s_i(pin_lvl[PIN_SDI]), .err_flag_i(err_q),
        .diag_word_i(diag_word_i), .rx_word_o(rx_word),
        .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o)
    );

    // Sticky error flag: set by mode events or bad frames, cleared by good ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b1;
        end else if (err_set_i) begin
            err_q <= 1'b1;
        end else if (evt.cs_rise) begin
            err_q <= ~len_ok;
        end
    end

    // Command latch: accept the received word at deselect when the length is legal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_word_o <= CMD_RST;
            cmd_stb_o  <= 1'b0;
        end else begin
            cmd_stb_o <= evt.cs_rise && len_ok;
            if (evt.cs_rise && len_ok) cmd_word_o <= rx_word;
        end
    end

endmodule

// File: rtl/spi_frame_slave_chk.sv
// Module: property checker for the serial command port, bound to the top.
// What it does: checks strobe shape, command stability, error flag causes and
// output enable at latch time.
// Assumes: it observes the top-level ports and the internal error flag.
module spi_frame_slave_chk #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              err_set_i,
    input logic              err_q,
    input logic              cmd_stb_o,
    input logic [WORD_W-1:0] cmd_word_o,
    input logic              sdo_oe_o
);

    // R2: the strobe lasts a single clock.
    a_r2_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb_o |=> !cmd_stb_o);

    // R2: the command word moves only together with the strobe.
    a_r2_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_stb_o |-> $stable(cmd_word_o));

    // R7: a set request raises the flag on the next clock.
    a_r7_set_flag: assert property (@(posedge clk) disable iff (!rst_n)
        err_set_i |=> err_q);

    // R7: an accepted frame leaves the flag clear unless a set request coincided.
    a_r7_clear_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb_o && !$past(err_set_i)) |-> !err_q);

    // R5: the flag rises only from a set request or at the end of a frame.
    a_r5_err_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> ($past(err_set_i) || !sdo_oe_o));

    // R8: a word is latched only after the output has been released.
    a_r8_oe_low_at_latch: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb_o |-> !sdo_oe_o);

endmodule

bind spi_frame_slave spi_frame_slave_chk #(.WORD_W(WORD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .err_set_i(err_set_i), .err_q(err_q),
    .cmd_stb_o(cmd_stb_o), .cmd_word_o(cmd_word_o), .sdo_oe_o(sdo_oe_o)
);

// File: tb/spi_frame_slave_test.sv
// Bench: scoreboard test of the frame-checked serial command port.
// A frame task drives the serial pins and queues the expected command words;
// a monitor pops and compares them whenever a strobe appears.
module spi_frame_slave_test;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;    // system clocks per serial phase
    localparam int WDOG       = 150000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cs_n, sclk, sdi, err_set;
    logic [15:0] diag;
    logic        sdo, sdo_oe, cmd_stb;
    logic [15:0] cmd_word;

    int n_checks = 0;
    int n_errors = 0;
    logic [15:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_frame_slave uut (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .sdi_i(sdi),
        .sdo_o(sdo), .sdo_oe_o(sdo_oe), .diag_word_i(diag),
        .err_set_i(err_set), .cmd_word_o(cmd_word), .cmd_stb_o(cmd_stb)
    );

    task automatic check(input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drive one frame of nbits; tx bit k is tx[nbits-1-k]. Returns the error
    // window level and the bits read on each launch edge.
    task automatic run_frame(input int nbits, input logic [63:0] tx,
                             input logic ter_si, output logic ter_seen,
                             output logic [63:0] rx);
        logic [15:0] diag_before;
        diag_before = diag;
        rx  = '0;
        sdi = ter_si;
        if (nbits >= 16 && nbits % 8 == 0) exp_q.push_back(tx[15:0]);
        wait_clk(HALF);
        cs_n = 1'b0;
        wait_clk(HALF);
        diag = ~diag_before;               // R3: late change must be ignored
        wait_clk(HALF);
        ter_seen = sdo;
        check("R8 oe during frame", 64'(sdo_oe), 64'd1);
        sdi = 1'b0;
        wait_clk(HALF);
        for (int k = 0; k < nbits; k++) begin
            sclk = 1'b1;
            wait_clk(HALF);
            rx  = {rx[62:0], sdo};
            sdi = tx[nbits-1-k];
            wait_clk(HALF);
            sclk = 1'b0;
            wait_clk(HALF);
        end
        cs_n = 1'b1;
        wait_clk(2*HALF);
        sdi = 1'b0;
        check("R8 oe after frame", 64'(sdo_oe), 64'd0);
        diag = diag_before;
    endtask

    // Monitor: compares each strobe against the expected queue.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && cmd_stb === 1'b1) begin
            if (exp_q.size() == 0) begin
                n_checks++;
                n_errors++;
                $display("FAIL R5 unexpected strobe: actual %0h expected none",
                         cmd_word);
            end else begin
                check("R2 latched word", 64'(cmd_word), 64'(exp_q.pop_front()));
            end
        end
    end

    task automatic report;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        wait_clk(WDOG);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        logic        ter;
        logic [63:0] rx;
        rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; sdi = 1'b0;
        err_set = 1'b0; diag = 16'h0;
        wait_clk(5);
        check("R1 oe in reset", 64'(sdo_oe), 64'd0);
        rst_n = 1'b1;
        wait_clk(4);
        check("R1 oe", 64'(sdo_oe), 64'd0);
        check("R1 sdo", 64'(sdo), 64'd0);
        check("R1 strobe", 64'(cmd_stb), 64'd0);
        check("R1 cmd reset", 64'(cmd_word), 64'hFFFF);

        // First valid frame: flag set from reset, diag shifted out.
        diag = 16'h1234;
        run_frame(16, 64'hA5C3, 1'b0, ter, rx);
        check("R1 error flag after reset", 64'(ter), 64'd1);
        check("R3 diag out", rx[15:0], 64'h1234);
        check("R2 cmd word", 64'(cmd_word), 64'hA5C3);

        // Valid frame cleared the flag.
        diag = 16'h0F0F;
        run_frame(16, 64'h3C5A, 1'b0, ter, rx);
        check("R7 cleared by valid frame", 64'(ter), 64'd0);
        check("R3 diag out 2", rx[15:0], 64'h0F0F);

        // Error window ORs in the input level.
        run_frame(16, 64'h0001, 1'b1, ter, rx);
        check("R6 window ORs sdi", 64'(ter), 64'd1);

        // Too-short frame: rejected.
        run_frame(12, 64'hABC, 1'b0, ter, rx);
        check("R6 window flag low", 64'(ter), 64'd0);
        check("R5 short frame keeps cmd", 64'(cmd_word), 64'h0001);

        // 24-bit frame: flag from the short frame; pass-through of early bits.
        diag = 16'hBEEF;
        run_frame(24, 64'hC0FFEE, 1'b0, ter, rx);
        check("R5 short frame set flag", 64'(ter), 64'd1);
        check("R4 diag part", rx[23:8], 64'hBEEF);
        check("R4 passthrough", rx[7:0], 64'hC0);
        check("R2 last 16 bits", 64'(cmd_word), 64'hFFEE);

        // 20 bits: not a multiple of 8.
        run_frame(20, 64'h12345, 1'b0, ter, rx);
        check("R5 20-bit keeps cmd", 64'(cmd_word), 64'hFFEE);

        // 32 bits: valid, flag from the 20-bit frame.
        diag = 16'h5AA5;
        run_frame(32, 64'hDEADBEEF, 1'b0, ter, rx);
        check("R5 20-bit set flag", 64'(ter), 64'd1);
        check("R4 passthrough 32", rx[15:0], 64'hDEAD);
        check("R2 cmd 32", 64'(cmd_word), 64'hBEEF);

        // Set request from the mode logic.
        err_set = 1'b1;
        wait_clk(1);
        err_set = 1'b0;
        run_frame(16, 64'h7E81, 1'b0, ter, rx);
        check("R7 set request", 64'(ter), 64'd1);

        // Chip select toggle with no clocks: invalid.
        run_frame(0, 64'h0, 1'b0, ter, rx);
        check("R7 clear before empty frame", 64'(ter), 64'd0);
        check("R5 empty frame keeps cmd", 64'(cmd_word), 64'h7E81);
        run_frame(16, 64'h0246, 1'b0, ter, rx);
        check("R5 empty frame set flag", 64'(ter), 64'd1);

        wait_clk(4);
        check("R2 all expected words seen", 64'(exp_q.size()), 64'd0);
        report();
    end

endmodule